// File: doc/BRIEF.md
# Level Interrupt Combiner

This block gathers sixteen level-sensitive interrupt request lines from devices on a board and merges them into a single interrupt line for a host processor. Each request line is first brought into the block's clock domain and then recorded in a sticky pending register. A separate enable register chooses which pending requests may drive the shared line. The shared line is active low because the host detects it on a falling edge.

The host reaches both registers through a small synchronous port with a one-bit register select, a write strobe and 16-bit data in each direction. A pending bit is cleared by writing a zero into its position. Writing a one leaves the bit as it is. A clear does not stick while the source is still asserted. This means a handler must quiet the device before it acknowledges the bit. If it does not, the request is recorded again at once.

Top module: `irq_combiner`

## Requirements
- R1: After a synchronous active-low reset, the enable register and the pending register both read 0x0000, and `irq_n_o` is high.
- R2: A write with `reg_sel_i` = 0 loads `wr_data_i` into the enable register. A read returns the register picked by `reg_sel_i` (0 = enable, 1 = pending) on `rd_data_o` one clock after the select is presented.
- R3: A source held high sets its pending bit on the third rising edge after the change. Two edges go to the synchronizer and one to the latch.
- R4: A write with `reg_sel_i` = 1 clears each pending bit whose data bit is 0. Pending bits whose data bit is 1 are left unchanged.
- R5: A clear of a pending bit has no effect while the synchronized source is high. If a set and a clear fall in the same cycle, the set wins.
- R6: `irq_n_o` goes low one clock after the bitwise AND of the pending and enable registers becomes nonzero.
- R7: `irq_n_o` returns high one clock after the last enabled pending bit is cleared or masked.
- R8: Pending bits latch whether or not the source is enabled. A disabled pending bit does not pull `irq_n_o` low, but it does once it is enabled.
- R9: A pending bit stays set after its source goes low, until the host clears it. Sources 0 and 15 behave like every other source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| src_i | input | 16 | Level interrupt requests, active high, asynchronous |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 pending |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data of the selected register |
| irq_n_o | output | 1 | Combined interrupt, active low, registered |

## Verification
A change on a source line reaches the pending register on the third rising edge and reaches `irq_n_o` on the fourth. A register write takes effect at its own edge and shows on `irq_n_o` one edge later. A read shows the value the register held before the edge that captures it. The bench drives inputs one time unit after a rising edge and counts the edges each task advances. Each value is sampled just after the edge on which it is due. The bench also samples one edge earlier, where the output must not yet have moved, so that an extra or a missing register stage is caught.

// File: rtl/irqc_pkg.sv
// Shared definitions for the level interrupt combiner.
// Assumes a single clock domain for the register port.
package irqc_pkg;

    // Register select encoding on the host port
    typedef enum logic {
        SEL_ENABLE  = 1'b0,
        SEL_PENDING = 1'b1
    } reg_sel_e;

    localparam int unsigned DEF_NUM_SRC     = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/irqc_sync.sv
// Multi-stage flop synchronizer for a vector of asynchronous level inputs.
// Assumes the inputs are slow levels, so bits need no mutual coherence.
module irqc_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw asynchronous levels
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q[g] <= '0;
                else         chain_q[g] <= async_i;
            end
        end else begin : g_rest
            // Later stages shift the value onward to settle metastability
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q[g] <= '0;
                else         chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqc_pending.sv
// Sticky pending register: bits are set by synchronized sources and cleared
// by a host write of zero. A set in the same cycle as a clear wins.
// Assumes set_i is already synchronous to clk_i.
module irqc_pending #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] set_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] pend_o
);

    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] keep_mask;
    logic [WIDTH-1:0] pend_d;

    // Bits written with zero are dropped; all others are kept
    always_comb begin
        keep_mask = wr_en_i ? wr_data_i : {WIDTH{1'b1}};
        pend_d    = (pend_q & keep_mask) | set_i;
    end

    // Hold the pending state across cycles
    always_ff @(posedge clk_i) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irqc_regport.sv
// Host register port: decodes writes, holds the enable register and returns
// registered read data one clock after the select is presented.
// Assumes a write and a read may share a cycle; the read shows the old value.
module irqc_regport #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             reg_sel_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [WIDTH-1:0] pend_i,
    output logic [WIDTH-1:0] enable_o,
    output logic             pend_wr_o,
    output logic [WIDTH-1:0] rd_data_o
);
    import irqc_pkg::*;

    reg_sel_e         sel;
    logic [WIDTH-1:0] enable_q;
    logic [WIDTH-1:0] rd_q;
    logic [WIDTH-1:0] rd_mux;

    assign sel = reg_sel_e'(reg_sel_i);

    // Decode the write strobe toward the pending register
    always_comb begin
        pend_wr_o = wr_en_i && (sel == SEL_PENDING);
    end

    // Pick the register to read
    always_comb begin
        case (sel)
            SEL_ENABLE:  rd_mux = enable_q;
            SEL_PENDING: rd_mux = pend_i;
            default:     rd_mux = '0;
        endcase
    end

    // Enable register loads on a write to its select
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                            enable_q <= '0;
        else if (wr_en_i && sel == SEL_ENABLE)  enable_q <= wr_data_i;
    end

    // Read data register gives one cycle of read latency
    always_ff @(posedge clk_i) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_mux;
    end

    assign enable_o  = enable_q;
    assign rd_data_o = rd_q;

endmodule

// File: rtl/irq_combiner.sv
// Level interrupt combiner top: synchronizes the sources, latches them into
// the pending register, masks with the enable register and drives one
// registered active-low interrupt line.
// Assumes src_i levels are held until the host services the device.
module irq_combiner #(
    parameter int unsigned NUM_SRC     = irqc_pkg::DEF_NUM_SRC,
    parameter int unsigned SYNC_STAGES = irqc_pkg::DEF_SYNC_STAGES
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_sel_i,
    input  logic               wr_en_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_n_o
);

    logic [NUM_SRC-1:0] sync_src;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               pend_wr;
    logic               any_live;
    logic               irq_n_q;

    irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (sync_src)
    );

    irqc_pending #(.WIDTH(NUM_SRC)) pend_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (sync_src),
        .wr_en_i   (pend_wr),
        .wr_data_i (wr_data_i),
        .pend_o    (status_q)
    );

    irqc_regport #(.WIDTH(NUM_SRC)) port_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .reg_sel_i (reg_sel_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .pend_i    (status_q),
        .enable_o  (mask_q),
        .pend_wr_o (pend_wr),
        .rd_data_o (rd_data_o)
    );

    // Any enabled pending source
    always_comb begin
        any_live = |(status_q & mask_q);
    end

    // Register the line so it never glitches
    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_n_q <= 1'b1;
        else         irq_n_q <= ~any_live;
    end

    assign irq_n_o = irq_n_q;

endmodule

// File: rtl/irqc_chk.sv
// Assertion checker for the level interrupt combiner, bound to the top.
module irqc_chk #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_sel,
    input logic         wr_en,
    input logic [N-1:0] wr_data,
    input logic [N-1:0] sync_src,
    input logic [N-1:0] status_q,
    input logic [N-1:0] mask_q,
    input logic         irq_n
);

    // R3
    src_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_src != '0) |=> ((status_q & $past(sync_src)) == $past(sync_src)));

    // R9
    pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4
    write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel) |=>
            ((status_q & $past(status_q & wr_data)) == $past(status_q & wr_data)));

    // R2
    enable_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !reg_sel) |=> $stable(mask_q));

    // R6
    irq_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & mask_q) != '0) |=> !irq_n);

    // R7
    irq_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & mask_q) == '0) |=> irq_n);

endmodule

bind irq_combiner irqc_chk #(.N(NUM_SRC)) chk_i (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .reg_sel  (reg_sel_i),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .sync_src (sync_src),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_n    (irq_n_o)
);

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         sel = 1'b0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_combiner dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .src_i     (src),
        .reg_sel_i (sel),
        .wr_en_i   (wr_en),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .irq_n_o   (irq_n)
    );

    // Advance n rising edges, then settle one time unit past the edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One-edge write; register changes at that edge
    task automatic write_reg(input logic s, input logic [N-1:0] d);
        sel = s; wdata = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    // Read shows the value held before the capturing edge
    task automatic read_reg(input logic s, output logic [N-1:0] d);
        sel = s;
        step(1);
        d = rdata;
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        check("R1 irq after reset", {15'd0, irq_n}, 16'h0001);
        check("R1 rdata after reset", rdata, 16'h0000);
        read_reg(1'b0, v); check("R1 enable reset", v, 16'h0000);
        read_reg(1'b1, v); check("R1 pending reset", v, 16'h0000);
    endtask

    task automatic t_enable_rw();
        logic [N-1:0] v;
        write_reg(1'b0, 16'hA5C3);
        read_reg(1'b0, v); check("R2 enable readback", v, 16'hA5C3);
        write_reg(1'b0, 16'h0000);
        read_reg(1'b0, v); check("R2 enable cleared", v, 16'h0000);
    endtask

    task automatic t_latch_masked();
        logic [N-1:0] v;
        src = 16'h0008;
        step(2);
        read_reg(1'b1, v); check("R3 not yet set at edge 2", v, 16'h0000);
        step(0);
        read_reg(1'b1, v); check("R3 set by edge 3", v, 16'h0008);
        check("R8 masked no irq", {15'd0, irq_n}, 16'h0001);
        src = 16'h0000;
        step(4);
        read_reg(1'b1, v); check("R9 sticky after source low", v, 16'h0008);
        write_reg(1'b0, 16'h0008);
        check("R6 irq not before one edge", {15'd0, irq_n}, 16'h0001);
        step(1);
        check("R8 irq after enable", {15'd0, irq_n}, 16'h0000);
        write_reg(1'b1, 16'hFFFF);
        read_reg(1'b1, v); check("R4 write ones keeps", v, 16'h0008);
        write_reg(1'b1, 16'hFFF7);
        check("R7 irq still low at clear edge", {15'd0, irq_n}, 16'h0000);
        step(1);
        check("R7 irq high one edge after clear", {15'd0, irq_n}, 16'h0001);
        read_reg(1'b1, v); check("R4 cleared by zero", v, 16'h0000);
    endtask

    task automatic t_clear_while_active();
        logic [N-1:0] v;
        write_reg(1'b0, 16'h0020);
        src = 16'h0020;
        step(3);
        check("R6 irq not yet at edge 3", {15'd0, irq_n}, 16'h0001);
        step(1);
        check("R6 irq low at edge 4", {15'd0, irq_n}, 16'h0000);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R5 clear ignored while active", v, 16'h0020);
        check("R5 irq stays low", {15'd0, irq_n}, 16'h0000);
        src = 16'h0000;
        step(4);
        write_reg(1'b1, 16'h0000);
        read_reg(1'b1, v); check("R5 clear after source low", v, 16'h0000);
        check("R7 irq released", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_edges();
        logic [N-1:0] v;
        write_reg(1'b0, 16'h0001);
        src = 16'h8001;
        step(4);
        read_reg(1'b1, v); check("R9 bits 0 and 15 latch", v, 16'h8001);
        check("R6 irq from bit 0", {15'd0, irq_n}, 16'h0000);
        src = 16'h0000;
        step(4);
        write_reg(1'b1, 16'hFFFE);
        step(1);
        check("R7 irq high with only masked bit 15", {15'd0, irq_n}, 16'h0001);
        read_reg(1'b1, v); check("R8 bit 15 still pending", v, 16'h8000);
        write_reg(1'b0, 16'h8000);
        step(1);
        check("R8 enabling bit 15 asserts", {15'd0, irq_n}, 16'h0000);
        write_reg(1'b0, 16'h0000);
        step(1);
        check("R7 masking releases", {15'd0, irq_n}, 16'h0001);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(0);
        t_reset();
        t_enable_rw();
        t_latch_masked();
        t_clear_while_active();
        t_edges();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule